// File: doc/BRIEF.md
# Slot-Interleaved Swap Lock Memory

This block holds a small bank of hardware lock flags shared by the virtual processors of a barrel pipeline. In that pipeline one pipeline of depth N serves N virtual processors, and each one issues in its own clock slot in strict rotation. A request arrives with the id of the virtual processor that owns the current slot. Because only one slot is served per clock, an operation that completes within that clock is atomic. No arbitration or bus locking is needed.

There are two operations. A test-and-set always writes a one into the selected flag, and in the same cycle it returns the value the flag held just before the write. A returned zero means the caller now holds the lock. A returned one means another holder already had it, and the caller retries in its next slot. A release clears the flag, but only when the requester is the recorded holder. A release from any other id, or a release of a free flag, leaves the state as it was and raises a one-cycle error. Each flag keeps the id of its holder, and the busy bits and holder ids are visible on output ports.

The request side uses a valid-only stream. The block is always ready, so there is no back-pressure. The response is combinational in the request's cycle, which models a memory clocked on the opposite edge: the old value is read half a cycle before the write is captured. State changes at the rising clock edge that ends the request cycle.

Top module: `swap_lock_mem`

## Requirements
- R1: After reset every lock is free (`lock_busy_o` all zero) and every owner field reads zero.
- R2: A test-and-set (`req_rel_i`=0) on a free lock returns `rsp_held_o`=0 in the request cycle. After the next rising edge the lock is busy and its owner field holds `req_vp_i`.
- R3: A test-and-set on a held lock returns `rsp_held_o`=1 in the request cycle. The lock stays busy and its owner field is unchanged.
- R4: A release (`req_rel_i`=1) by the recorded owner of a busy lock clears the busy bit and the owner field after the next edge, with `err_o`=0.
- R5: A release from a non-owner, or of a free lock, is ignored: the busy bits and owner fields are unchanged after the edge, and `err_o` is 1 in the request cycle.
- R6: A request changes only the addressed lock. At most one busy bit changes per cycle.
- R7: The block never stalls. `rsp_valid_o` equals `req_valid_i` in the same cycle for every operation, including a failed acquire.
- R8: With `req_valid_i`=0 there is no state change, and `err_o`=0.
- R9: Owner field i occupies bits `[i*VP_W +: VP_W]` of `lock_owner_o`. Busy bit i is `lock_busy_o[i]`. The lock index is `req_lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present in this slot |
| req_rel_i | input | 1 | 0 = test-and-set, 1 = release |
| req_lock_i | input | LOCK_W | Lock index |
| req_vp_i | input | VP_W | Id of the virtual processor owning the slot |
| rsp_valid_o | output | 1 | Response valid, same cycle as the request |
| rsp_held_o | output | 1 | Busy value of the lock before this access |
| err_o | output | 1 | Illegal release pulse |
| lock_busy_o | output | NUM_LOCKS | Busy bit per lock |
| lock_owner_o | output | NUM_LOCKS*VP_W | Owner id per lock |

## Verification
The bench builds the block with its defaults: 16 locks and 4 virtual processors, with the requester id stepping through the rotation. Random traffic is confined to locks 0, 1, 2 and 15, which puts both ends of the index range within reach. It also makes contended acquires, double acquires by the holder, foreign releases and releases of free locks frequent. Directed steps cover each of these cases in isolation.

// File: rtl/slm_pkg.sv
package slm_pkg;
  typedef enum logic {
    OP_TAS = 1'b0,
    OP_REL = 1'b1
  } slm_op_e;
endpackage

// File: rtl/slm_cell.sv
module slm_cell #(
  parameter int VP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [VP_W-1:0] vp_i,
  output logic            busy_o,
  output logic [VP_W-1:0] owner_o
);
  logic            busy_q;
  logic [VP_W-1:0] owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (set_i) begin
      // the flag is written with one regardless; the holder id only on a fresh grab
      if (!busy_q) owner_q <= vp_i;
      busy_q <= 1'b1;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  assert_set_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(set_i));
  assert_clear_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(clr_i));
  assert_owner_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !$past(clr_i)) |-> $stable(owner_q));
endmodule

// File: rtl/slm_read_mux.sv
module slm_read_mux #(
  parameter int NUM_LOCKS = 16,
  parameter int LOCK_W    = 4,
  parameter int VP_W      = 2
) (
  input  logic [NUM_LOCKS-1:0]      busy_vec_i,
  input  logic [NUM_LOCKS*VP_W-1:0] owner_flat_i,
  input  logic [LOCK_W-1:0]         lock_i,
  output logic                      sel_busy_o,
  output logic [VP_W-1:0]           sel_owner_o
);
  always_comb begin
    sel_busy_o  = 1'b0;
    sel_owner_o = '0;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      if (lock_i == LOCK_W'(i)) begin
        sel_busy_o  = busy_vec_i[i];
        sel_owner_o = owner_flat_i[i*VP_W +: VP_W];
      end
    end
  end
endmodule

// File: rtl/slm_decode.sv
module slm_decode
  import slm_pkg::*;
#(
  parameter int NUM_LOCKS = 16,
  parameter int LOCK_W    = 4,
  parameter int VP_W      = 2
) (
  input  logic                 valid_i,
  input  logic                 rel_i,
  input  logic [LOCK_W-1:0]    lock_i,
  input  logic [VP_W-1:0]      vp_i,
  input  logic                 sel_busy_i,
  input  logic [VP_W-1:0]      sel_owner_i,
  output logic [NUM_LOCKS-1:0] set_vec_o,
  output logic [NUM_LOCKS-1:0] clr_vec_o,
  output logic                 err_o
);
  slm_op_e op;
  logic    rel_ok;

  assign op     = slm_op_e'(rel_i);
  assign rel_ok = sel_busy_i && (sel_owner_i == vp_i);

  always_comb begin
    set_vec_o = '0;
    clr_vec_o = '0;
    err_o     = 1'b0;
    if (valid_i) begin
      for (int i = 0; i < NUM_LOCKS; i++) begin
        if (lock_i == LOCK_W'(i)) begin
          set_vec_o[i] = (op == OP_TAS);
          clr_vec_o[i] = (op == OP_REL) && rel_ok;
        end
      end
      err_o = (op == OP_REL) && !rel_ok;
    end
  end
endmodule

// File: rtl/swap_lock_mem.sv
module swap_lock_mem #(
  parameter int NUM_LOCKS = 16,
  parameter int NUM_VPS   = 4,
  localparam int LOCK_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int VP_W     = (NUM_VPS > 1) ? $clog2(NUM_VPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic                      req_rel_i,
  input  logic [LOCK_W-1:0]         req_lock_i,
  input  logic [VP_W-1:0]           req_vp_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_held_o,
  output logic                      err_o,
  output logic [NUM_LOCKS-1:0]      lock_busy_o,
  output logic [NUM_LOCKS*VP_W-1:0] lock_owner_o
);
  logic [NUM_LOCKS-1:0]      busy_vec;
  logic [NUM_LOCKS*VP_W-1:0] owner_flat;
  logic [NUM_LOCKS-1:0]      set_vec;
  logic [NUM_LOCKS-1:0]      clr_vec;
  logic                      sel_busy;
  logic [VP_W-1:0]           sel_owner;

  slm_read_mux #(.NUM_LOCKS(NUM_LOCKS), .LOCK_W(LOCK_W), .VP_W(VP_W)) u_rd (
    .busy_vec_i  (busy_vec),
    .owner_flat_i(owner_flat),
    .lock_i      (req_lock_i),
    .sel_busy_o  (sel_busy),
    .sel_owner_o (sel_owner)
  );

  slm_decode #(.NUM_LOCKS(NUM_LOCKS), .LOCK_W(LOCK_W), .VP_W(VP_W)) u_dec (
    .valid_i    (req_valid_i),
    .rel_i      (req_rel_i),
    .lock_i     (req_lock_i),
    .vp_i       (req_vp_i),
    .sel_busy_i (sel_busy),
    .sel_owner_i(sel_owner),
    .set_vec_o  (set_vec),
    .clr_vec_o  (clr_vec),
    .err_o      (err_o)
  );

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    slm_cell #(.VP_W(VP_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .vp_i   (req_vp_i),
      .busy_o (busy_vec[g]),
      .owner_o(owner_flat[g*VP_W +: VP_W])
    );
  end

  // old value leaves in the request cycle; the write lands at the closing edge
  assign rsp_valid_o  = req_valid_i;
  assign rsp_held_o   = sel_busy;
  assign lock_busy_o  = busy_vec;
  assign lock_owner_o = owner_flat;

  assert_acquire_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_rel_i) |=> busy_vec[$past(req_lock_i)]);
  assert_bad_release_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> ($stable(busy_vec) && $stable(owner_flat)));
  assert_single_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_vec ^ $past(busy_vec)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> ($stable(busy_vec) && $stable(owner_flat)));
endmodule

// File: tb/swap_lock_mem_tb.sv
module swap_lock_mem_tb;
  localparam int NL = 16;
  localparam int NV = 4;
  localparam int LW = 4;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rel = 1'b0;
  logic [LW-1:0] req_lock = '0;
  logic [VW-1:0] req_vp = '0;
  logic rsp_valid, rsp_held, err;
  logic [NL-1:0] busy;
  logic [NL*VW-1:0] owner;

  int checks = 0, errors = 0;
  logic          m_busy [NL];
  logic [VW-1:0] m_own  [NL];

  always #4 clk = ~clk;

  swap_lock_mem #(.NUM_LOCKS(NL), .NUM_VPS(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_rel_i(req_rel),
    .req_lock_i(req_lock), .req_vp_i(req_vp), .rsp_valid_o(rsp_valid),
    .rsp_held_o(rsp_held), .err_o(err), .lock_busy_o(busy), .lock_owner_o(owner));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic v, input logic rel, input int l, input int vp);
    return v && rel && !(m_busy[l] && m_own[l] == VW'(vp));
  endfunction

  task automatic check_state(input string req);
    logic [NL-1:0] eb;
    logic [NL*VW-1:0] eo;
    for (int i = 0; i < NL; i++) begin
      eb[i] = m_busy[i];
      eo[i*VW +: VW] = m_own[i];
    end
    chk({req, " busy"}, 64'(busy), 64'(eb));
    chk({req, " owner"}, 64'(owner), 64'(eo));
  endtask

  // drive at negedge, check same-cycle response, then state after the edge
  task automatic do_req(input string req, input logic v, input logic rel, input int l, input int vp);
    logic e;
    req_valid = v; req_rel = rel; req_lock = LW'(l); req_vp = VW'(vp);
    #2;
    e = exp_err(v, rel, l, vp);
    chk({req, " R7 rsp_valid"}, 64'(rsp_valid), 64'(v));
    if (v && !rel) chk({req, " held"}, 64'(rsp_held), 64'(m_busy[l]));
    chk({req, " err"}, 64'(err), 64'(e));
    @(posedge clk);
    if (v && !rel && !m_busy[l]) begin m_busy[l] = 1'b1; m_own[l] = VW'(vp); end
    else if (v && rel && !e) begin m_busy[l] = 1'b0; m_own[l] = '0; end
    @(negedge clk);
    check_state(req);
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_busy[i] = 1'b0; m_own[i] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_state("R1 reset");
    do_req("R2 grab free", 1, 0, 3, 0);
    do_req("R3 contended", 1, 0, 3, 1);
    do_req("R3 holder again", 1, 0, 3, 0);
    do_req("R5 foreign release", 1, 1, 3, 2);
    do_req("R8 idle", 0, 1, 3, 0);
    do_req("R4 owner release", 1, 1, 3, 0);
    do_req("R5 free release", 1, 1, 3, 0);
    do_req("R6 R9 top lock", 1, 0, 15, 3);
    do_req("R6 R9 bottom lock", 1, 0, 0, 2);
    do_req("R4 top release", 1, 1, 15, 3);
    for (int n = 0; n < 400; n++) begin
      int r, l;
      r = int'($urandom % 4);
      l = (r == 3) ? 15 : r;
      do_req("R2 R3 R4 R5 R6 random", ($urandom % 8) != 0, ($urandom % 3) == 0, l, n % NV);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule